// File: doc/BRIEF.md
# Byte-Wide Master/Slave Serial Peripheral Port

This block moves one byte at a time over a four-wire synchronous serial link. A host sets it up through a small register port holding an 8-bit control word, a compare byte and a data register. As master, the port makes the serial clock itself, from either the reference clock or an external timer tick, divided by a programmable power of two. It pulls its select output low for the length of the byte and shifts data out and in at the same time. As slave, it follows an external serial clock while its select input is low. It can also let go of its data-out pin so that another device can drive it.

Each complete byte received goes into a receive buffer and raises an "available" flag, which in turn raises the interrupt when the interrupt enable input is high. Reading the buffer clears the flag. In slave mode, a byte that arrives while the previous one is still unread sets a sticky overrun flag, and only a written zero clears it. With compare mode on, only a byte equal to the compare register reaches the buffer.

Top module: `spi_port`

## Requirements
- R1: Control bit 0 enables the port. Reset clears the whole control word, so the port comes up as a disabled slave with compare off. While the port is disabled, data-out is not driven (`sdo_oe`=0), the select output stays high and a data write starts no transfer.
- R2: Control bit 7 selects the mode: 1 is master and 0 is slave. Register addresses are 0 for control, 1 for compare and 2 for data.
- R3: In master mode, each half period of `sck_out` lasts 2^n clock-source pulses, where n is control bits 2:1. This gives the source divided by 2, 4, 8 or 16.
- R4: Control bit 6 selects the clock source. When it is 0, every reference clock cycle is a source pulse. When it is 1, only cycles with `tick_in` high count as source pulses.
- R5: Control bit 5 sets the clock phase. The serial clock idles at the level of bit 5. When bit 5 is 0, data is sampled on rising edges and changed on falling edges. When bit 5 is 1, data is sampled on falling edges and changed on rising edges.
- R6: A transfer is 8 bits, most significant bit first. In master mode, writing address 2 while the port is idle loads the transmit byte and starts the transfer. `sel_out` stays low from start to finish, for all 16 clock edges.
- R7: A received byte goes to the receive buffer, which is read at address 2, and sets control bit 4. A read of address 2 clears bit 4. `irq` equals bit 4 ANDed with `irq_en`.
- R8: In slave mode, control bit 1 is set when a byte completes while bit 4 is still set. Writing 1 to bit 1 leaves it unchanged, and writing 0 clears it.
- R9: In slave mode with control bit 2 set, data-out is released (`sdo_oe`=0). With bit 2 clear and `sel_in` low, the slave drives one bit out for every bit it receives.
- R10: With control bit 3 set, a received byte that differs from the compare register is dropped. The buffer and bit 4 stay unchanged. A matching byte is stored as usual.
- R11: A slave ignores serial clock edges while `sel_in` is high. A later selected transfer starts from bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the available flag on address 2) |
| reg_addr | input | 2 | Register address: 0 control, 1 compare, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| tick_in | input | 1 | Alternate clock-source pulse from a timer |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Data-out drive enable |
| sel_in | input | 1 | Slave select input, active low |
| sel_out | output | 1 | Master select output, active low |
| sck_in | input | 1 | Serial clock input (slave) |
| sck_out | output | 1 | Serial clock output (master) |

## Verification
The checker watches every cycle for the following. A disabled port never drives data-out and never selects. A released slave never drives. The interrupt never rises without its enable. The overrun flag stays set until a control write. A slave's receive shifter never moves while it is deselected. A master select only falls right after a data write.

Some behaviour can only be shown by the bench's scenarios. These are the divider and source timing, the phase-dependent idle level and edge use, the MSB-first bit order in both directions, compare filtering, and the clearing of the available flag by a read. Each scenario runs a real transfer and compares the bits, the edge spacing and the register contents against values worked out in advance.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tick_in,
  input  logic       irq_en,
  output logic       irq,
  input  logic       sdi,
  output logic       sdo,
  output logic       sdo_oe,
  input  logic       sel_in,
  output logic       sel_out,
  input  logic       sck_in,
  output logic       sck_out
);
  localparam int EW = $clog2(2 * W);

  logic [7:0]    ctrl;
  logic [W-1:0]  cmp, rxbuf, tx_sr, rx_sr;
  logic          busy, sck_r, sck_q;
  logic [2:0]    dcnt;
  logic [EW-1:0] ecnt;

  wire en = ctrl[0];
  wire mst = ctrl[7];
  wire cmp_en = ctrl[3];
  wire cpha = ctrl[5];
  wire avail = ctrl[4];

  wire wr_ctrl = reg_wr && reg_addr == 2'd0;
  wire wr_cmp  = reg_wr && reg_addr == 2'd1;
  wire wr_dat  = reg_wr && reg_addr == 2'd2;
  wire rd_dat  = reg_rd && reg_addr == 2'd2;

  wire [3:0] half_lim = (4'd1 << ctrl[2:1]) - 4'd1;
  wire m_pulse  = busy && mst && en && (ctrl[6] ? tick_in : 1'b1);
  wire m_edge   = m_pulse && ({1'b0, dcnt} == half_lim);
  wire m_sample = m_edge && !ecnt[0];
  wire m_drive  = m_edge && ecnt[0];
  wire m_last   = m_edge && (ecnt == EW'(2 * W - 1));

  wire s_act    = en && !mst && !sel_in;
  wire s_rise   = sck_in && !sck_q;
  wire s_fall   = !sck_in && sck_q;
  wire s_sample = s_act && (cpha ? s_fall : s_rise);
  wire s_drive  = s_act && (cpha ? s_rise : s_fall);
  wire s_done   = s_sample && (ecnt == EW'(W - 1));

  wire [W-1:0] new_byte  = {rx_sr[W-2:0], sdi};
  wire         done      = m_last || s_done;
  wire [W-1:0] done_byte = m_last ? rx_sr : new_byte;
  wire         accept    = done && (!cmp_en || done_byte == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      cmp   <= '0;
      rxbuf <= '0;
      tx_sr <= '0;
      rx_sr <= '0;
      busy  <= 1'b0;
      sck_r <= 1'b0;
      sck_q <= 1'b0;
      dcnt  <= '0;
      ecnt  <= '0;
    end else begin
      sck_q <= sck_in;

      if (wr_ctrl) begin
        ctrl[7:5] <= reg_wdata[7:5];
        ctrl[3:2] <= reg_wdata[3:2];
        ctrl[0]   <= reg_wdata[0];
        ctrl[1]   <= reg_wdata[7] ? reg_wdata[1] : (ctrl[1] && reg_wdata[1] && !ctrl[7]);
      end
      if (wr_cmp) cmp <= reg_wdata[W-1:0];
      if (rd_dat) ctrl[4] <= 1'b0;
      if (accept) begin
        rxbuf   <= done_byte;
        ctrl[4] <= 1'b1;
        if (!mst && avail && !rd_dat) ctrl[1] <= 1'b1;
      end

      if (s_sample || m_sample) rx_sr <= new_byte;
      if (s_drive || m_drive) tx_sr <= tx_sr << 1;

      if (wr_dat && !busy) begin
        tx_sr <= reg_wdata[W-1:0];
        if (mst && en) begin
          busy  <= 1'b1;
          dcnt  <= '0;
          ecnt  <= '0;
          sck_r <= cpha;
        end
      end

      if (mst) begin
        if (m_pulse) dcnt <= m_edge ? 3'd0 : dcnt + 3'd1;
        if (m_edge) begin
          sck_r <= !sck_r;
          ecnt  <= ecnt + EW'(1);
          if (m_last) begin
            busy <= 1'b0;
            ecnt <= '0;
          end
        end
      end else begin
        busy <= 1'b0;
        if (!s_act) ecnt <= '0;
        else if (s_sample) ecnt <= s_done ? '0 : ecnt + EW'(1);
      end

      if (!en) begin
        busy <= 1'b0;
        ecnt <= '0;
      end
    end
  end

  assign sel_out = !busy;
  assign sck_out = busy ? sck_r : cpha;
  assign sdo     = tx_sr[W-1];
  assign sdo_oe  = en && (mst || (!ctrl[2] && !sel_in));
  assign irq     = avail && irq_en;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = ctrl;
      2'd1:    reg_rdata = 8'(cmp);
      2'd2:    reg_rdata = 8'(rxbuf);
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

module spi_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_wr,
  input logic [1:0]   reg_addr,
  input logic         sel_in,
  input logic         sel_out,
  input logic         sdo_oe,
  input logic         irq,
  input logic         irq_en,
  input logic [7:0]   ctrl,
  input logic [W-1:0] rx_sr
);
  a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |=> (ctrl[0] || (!sdo_oe && sel_out)));

  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[7] && ctrl[2]) |-> !sdo_oe);

  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);

  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[7] && ctrl[1] && !(reg_wr && reg_addr == 2'd0)) |=> ctrl[1]);

  a_r11_deselected_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && !ctrl[7] && sel_in) |=> $stable(rx_sr));

  a_r6_start_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_out) |-> $past(reg_wr && reg_addr == 2'd2));
endmodule

bind spi_port spi_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .sel_in(sel_in), .sel_out(sel_out), .sdo_oe(sdo_oe), .irq(irq),
  .irq_en(irq_en), .ctrl(ctrl), .rx_sr(rx_sr)
);

// File: tb/test_spi_port.sv
module test_spi_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic tick_in = 0, irq_en = 0, irq;
  logic sdi_drv = 0, loop = 0, sdi, sdo, sdo_oe;
  logic sel_in = 1, sel_out, sck_in = 0, sck_out;
  int checks = 0, errors = 0, cyc = 0, tick_cnt = 0;

  assign sdi = loop ? sdo : sdi_drv;

  spi_port i_spi_port (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tick_in(tick_in), .irq_en(irq_en), .irq(irq), .sdi(sdi), .sdo(sdo),
    .sdo_oe(sdo_oe), .sel_in(sel_in), .sel_out(sel_out), .sck_in(sck_in),
    .sck_out(sck_out)
  );

  always #2 clk = !clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    tick_cnt <= (tick_cnt == 2) ? 0 : tick_cnt + 1;
    tick_in <= (tick_cnt == 2);
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual cycle %0d expected under 100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic master_xfer(input logic [7:0] tx, input int half, input bit ph, input string req);
    logic [7:0] got = 0, v;
    int edges = 0, since = 0, bad_gap = 0, sel_hi = 0;
    logic prev;
    loop = 1;
    chk(sck_out == ph, "R5 idle level", sck_out, ph);
    @(negedge clk);
    reg_wr = 1; reg_addr = 2; reg_wdata = tx;
    @(negedge clk);
    reg_wr = 0;
    prev = sck_out;
    while (!sel_out) begin
      @(negedge clk);
      since++;
      if (sck_out != prev) begin
        if (edges > 0 && since != half) bad_gap++;
        if (edges % 2 == 0) got = {got[6:0], sdo};
        edges++;
        since = 0;
        prev = sck_out;
      end
      if (sel_out && edges < 16) sel_hi++;
    end
    loop = 0;
    chk(edges == 16, {req, " R6 edge count"}, edges, 16);
    chk(bad_gap == 0, {req, " R3 half period"}, bad_gap, 0);
    chk(sel_hi == 0, {req, " R6 select low"}, sel_hi, 0);
    chk(got == tx, {req, " R6 msb-first out"}, got, tx);
    wait_clk(1);
    peek(0, v);
    chk(v[4] == 1'b1, {req, " R7 avail"}, v[4], 1);
    rd(2, v);
    chk(v == tx, {req, " R7 rx buffer"}, v, tx);
  endtask

  task automatic slave_xfer(input logic [7:0] din, input bit ph, output logic [7:0] dout);
    sck_in = ph;
    @(negedge clk);
    sel_in = 0;
    wait_clk(2);
    for (int i = 7; i >= 0; i--) begin
      sdi_drv = din[i];
      wait_clk(2);
      dout[i] = sdo;
      sck_in = !ph;
      wait_clk(3);
      sck_in = ph;
      wait_clk(3);
    end
    sel_in = 1;
    wait_clk(2);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    peek(0, v);
    chk(v == 8'h00, "R1 R2 reset control", v, 0);
    chk(sdo_oe == 0 && sel_out == 1 && irq == 0, "R1 reset pins", {sdo_oe, sel_out, irq}, 3'b010);
  endtask

  task automatic t_disabled();
    wr(0, 8'h80);
    wr(2, 8'hC3);
    wait_clk(20);
    chk(sel_out == 1, "R1 disabled no transfer", sel_out, 1);
    chk(sdo_oe == 0, "R1 disabled no drive", sdo_oe, 0);
  endtask

  task automatic t_master_ref();
    logic [7:0] v;
    for (int d = 0; d < 4; d++) begin
      wr(0, 8'h81 | 8'(d << 1));
      master_xfer(8'hA5 ^ 8'(d * 17), 1 << d, 0, "R3 ref divider");
    end
    irq_en = 1;
    wr(0, 8'h81);
    loop = 1;
    wr(2, 8'h3C);
    wait_clk(40);
    loop = 0;
    chk(irq == 1, "R7 irq raised", irq, 1);
    rd(2, v);
    wait_clk(1);
    chk(irq == 0, "R7 irq cleared by read", irq, 0);
    irq_en = 0;
  endtask

  task automatic t_master_tick();
    wr(0, 8'hE1);
    wait_clk(1);
    master_xfer(8'h6E, 3, 1, "R4 R5 tick phase1");
    wr(0, 8'hE3);
    wait_clk(1);
    master_xfer(8'h91, 6, 1, "R4 tick div4");
  endtask

  task automatic t_slave();
    logic [7:0] o, v;
    wr(0, 8'h01);
    wr(2, 8'h3C);
    slave_xfer(8'h96, 0, o);
    chk(o == 8'h3C, "R9 slave out msb-first", o, 8'h3C);
    rd(2, v);
    chk(v == 8'h96, "R2 slave rx", v, 8'h96);
    wr(0, 8'h21);
    wr(2, 8'hC5);
    slave_xfer(8'h4B, 1, o);
    chk(o == 8'hC5, "R5 slave phase1 out", o, 8'hC5);
    rd(2, v);
    chk(v == 8'h4B, "R5 slave phase1 rx", v, 8'h4B);
  endtask

  task automatic t_overrun();
    logic [7:0] o, v;
    wr(0, 8'h01);
    slave_xfer(8'h11, 0, o);
    peek(0, v);
    chk(v[1] == 0, "R8 no overrun first", v[1], 0);
    slave_xfer(8'h22, 0, o);
    peek(0, v);
    chk(v[1] == 1, "R8 overrun set", v[1], 1);
    wr(0, 8'h03);
    peek(0, v);
    chk(v[1] == 1, "R8 write one keeps", v[1], 1);
    wr(0, 8'h01);
    peek(0, v);
    chk(v[1] == 0, "R8 write zero clears", v[1], 0);
    rd(2, v);
  endtask

  task automatic t_release();
    wr(0, 8'h05);
    @(negedge clk);
    sel_in = 0;
    wait_clk(2);
    chk(sdo_oe == 0, "R9 released", sdo_oe, 0);
    wr(0, 8'h01);
    wait_clk(1);
    chk(sdo_oe == 1, "R9 driven when selected", sdo_oe, 1);
    sel_in = 1;
    wait_clk(1);
    chk(sdo_oe == 0, "R9 idle when deselected", sdo_oe, 0);
  endtask

  task automatic t_compare();
    logic [7:0] o, v;
    wr(1, 8'h5A);
    wr(0, 8'h09);
    slave_xfer(8'h11, 0, o);
    peek(0, v);
    chk(v[4] == 0, "R10 mismatch dropped flag", v[4], 0);
    peek(2, v);
    chk(v != 8'h11, "R10 mismatch buffer kept", v, 0);
    slave_xfer(8'h5A, 0, o);
    peek(0, v);
    chk(v[4] == 1, "R10 match flag", v[4], 1);
    rd(2, v);
    chk(v == 8'h5A, "R10 match buffer", v, 8'h5A);
    wr(0, 8'h01);
  endtask

  task automatic t_deselect();
    logic [7:0] o, v;
    wr(0, 8'h01);
    sdi_drv = 1;
    for (int i = 0; i < 5; i++) begin
      sck_in = 1; wait_clk(3);
      sck_in = 0; wait_clk(3);
    end
    peek(0, v);
    chk(v[4] == 0, "R11 deselected edges ignored", v[4], 0);
    slave_xfer(8'h81, 0, o);
    rd(2, v);
    chk(v == 8'h81, "R11 fresh byte after deselect", v, 8'h81);
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1;
    wait_clk(2);
    t_reset();
    t_disabled();
    t_master_ref();
    t_master_tick();
    t_slave();
    t_overrun();
    t_release();
    t_compare();
    t_deselect();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule